// File: doc/BRIEF.md
# Grid Path Retrace Walker

This block turns a finished (or still-growing) arrival-direction map into an explicit route. Every cell of a rectangular grid records, as a one-hot nibble, which neighbour first delivered the wavefront to it, plus a flag that marks the cell as a wavefront origin. Given a destination cell, the walker repeatedly reads that cell's nibble and steps to the neighbour it names. It emits each visited coordinate in turn until it lands on an origin. Because each cell keeps only the earliest arrival, the emitted route is the minimum-cost route. When several origins were active, the route ends at whichever origin reached the destination first.

The host pulses `start` with a destination while the walker is idle. The walker drives a single-cycle read request at the direction store, which answers on the following cycle, and then offers one coordinate beat on a valid/ready stream. The store can be read while propagation is still running, so a walk may be started at any time. A map that is corrupt or incomplete stops the walk with an error beat instead of letting it wander.

Output stream rules: `out_valid` rises only when a beat is ready and stays high until the cycle in which `out_ready` is also high. While it waits, `out_row`, `out_col`, `out_last` and `out_err` hold steady. The walker issues no read and does not advance while a beat is outstanding, so holding `out_ready` low stalls the whole walk with no loss. The final beat of every walk carries `out_last`. A beat that carries `out_err` is always final.

Top module: `path_retrace_walker`

## Requirements
- R1: After reset the walker is idle: `busy`, `out_valid` and `rd_en` are all low.
- R2: A `start` pulse while idle, with an in-grid destination, produces a walk whose first beat is the destination coordinate.
- R3: Direction nibble bit 0 steps to row-1 (north), bit 1 to row+1 (south), bit 2 to col+1 (east) and bit 3 to col-1 (west). Each non-final beat is followed by a beat at the neighbour so named.
- R4: A cell whose origin flag is set ends the walk with `out_last`=1 and `out_err`=0, whatever its direction nibble holds.
- R5: A non-origin cell with an all-zero nibble (unreached) is emitted as the final beat with `out_err`=1.
- R6: A non-origin cell whose nibble has two or more bits set is emitted as the final beat with `out_err`=1.
- R7: A non-origin cell whose nibble points off the grid edge is emitted as the final beat with `out_err`=1.
- R8: A walk never exceeds ROWS*COLS beats. If beat number ROWS*COLS is not an origin, it carries `out_last`=1 and `out_err`=1.
- R9: While `out_valid` is high and `out_ready` is low, the beat stays valid and all beat fields stay unchanged.
- R10: `start` is ignored while `busy` is high; the running walk continues unchanged.
- R11: A destination with row >= ROWS or col >= COLS yields exactly one beat at that coordinate with `out_last`=1 and `out_err`=1, and issues no read.
- R12: Exactly one read (`rd_en` high for one cycle) precedes each in-grid beat. It addresses that beat's coordinate and never overlaps a valid beat. The store answers on `rd_dir`/`rd_src` in the cycle after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk; honoured only when idle |
| start_row | input | RW | Destination row |
| start_col | input | CW | Destination column |
| busy | output | 1 | High from an accepted start until the final beat is taken |
| rd_en | output | 1 | Read request to the direction store |
| rd_row | output | RW | Row being read |
| rd_col | output | CW | Column being read |
| rd_dir | input | 4 | One-hot arrival direction, valid the cycle after `rd_en` |
| rd_src | input | 1 | Origin flag, valid the cycle after `rd_en` |
| out_valid | output | 1 | Coordinate beat available |
| out_ready | input | 1 | Consumer accepts the beat |
| out_row | output | RW | Beat row |
| out_col | output | CW | Beat column |
| out_last | output | 1 | Final beat of the walk |
| out_err | output | 1 | Walk stopped on a fault (implies `out_last`) |

## Verification
A wrong decode of the direction nibble or a wrong neighbour step shows up one beat later: the next coordinate is not adjacent, or it is the wrong neighbour. The bench catches this at that beat by comparing against a walk it computes from its own copy of the map. A step-budget counter that is off by one changes the length of a looping walk, which is visible when the walk's final beat arrives. A fault in the handshake stage shows within one stalled cycle as a dropped, repeated or changed beat. A misplaced read shows within one cycle as a read address that differs from the beat that follows it.

// File: rtl/path_walk_pkg.sv
package path_walk_pkg;

  localparam int HEAD_N = 0;
  localparam int HEAD_S = 1;
  localparam int HEAD_E = 2;
  localparam int HEAD_W = 3;

  typedef enum logic [1:0] {
    WK_IDLE,
    WK_READ,
    WK_EVAL,
    WK_SEND
  } walk_state_e;

  typedef struct packed {
    logic up;
    logic down;
    logic right;
    logic left;
    logic none;
    logic many;
  } heading_t;

endpackage

// File: rtl/pw_heading_decode.sv
module pw_heading_decode
  import path_walk_pkg::*;
(
  input  logic [3:0] dir,
  output heading_t   hd
);

  logic [2:0] ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < 4; i++) begin
      ones = ones + {2'b00, dir[i]};
    end
  end

  always_comb begin
    hd.up    = dir[HEAD_N];
    hd.down  = dir[HEAD_S];
    hd.right = dir[HEAD_E];
    hd.left  = dir[HEAD_W];
    hd.none  = (ones == 3'd0);
    hd.many  = (ones > 3'd1);
  end

endmodule

// File: rtl/pw_neighbor.sv
module pw_neighbor
  import path_walk_pkg::*;
#(
  parameter int ROWS = 24,
  parameter int COLS = 25,
  parameter int RW   = 5,
  parameter int CW   = 5
) (
  input  logic [RW-1:0] cur_r,
  input  logic [CW-1:0] cur_c,
  input  heading_t      hd,
  output logic [RW-1:0] nxt_r,
  output logic [CW-1:0] nxt_c,
  output logic          leaves
);

  localparam logic [RW-1:0] LAST_R = RW'(ROWS - 1);
  localparam logic [CW-1:0] LAST_C = CW'(COLS - 1);

  always_comb begin
    nxt_r = cur_r;
    nxt_c = cur_c;
    if (hd.up)         nxt_r = cur_r - RW'(1);
    else if (hd.down)  nxt_r = cur_r + RW'(1);
    else if (hd.right) nxt_c = cur_c + CW'(1);
    else if (hd.left)  nxt_c = cur_c - CW'(1);
  end

  always_comb begin
    leaves = (hd.up    && (cur_r == '0))    ||
             (hd.down  && (cur_r == LAST_R)) ||
             (hd.right && (cur_c == LAST_C)) ||
             (hd.left  && (cur_c == '0));
  end

endmodule

// File: rtl/pw_step_budget.sv
module pw_step_budget #(
  parameter int LIMIT = 600,
  localparam int SW   = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic bump,
  output logic spent
);

  logic [SW-1:0] used;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      used <= '0;
    else if (clear)  used <= '0;
    else if (bump)   used <= used + SW'(1);
  end

  assign spent = (used == SW'(LIMIT - 1));

endmodule

// File: rtl/path_retrace_walker.sv
module path_retrace_walker
  import path_walk_pkg::*;
#(
  parameter  int ROWS = 24,
  parameter  int COLS = 25,
  localparam int RW   = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW   = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [RW-1:0] start_row,
  input  logic [CW-1:0] start_col,
  output logic          busy,
  output logic          rd_en,
  output logic [RW-1:0] rd_row,
  output logic [CW-1:0] rd_col,
  input  logic [3:0]    rd_dir,
  input  logic          rd_src,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [RW-1:0] out_row,
  output logic [CW-1:0] out_col,
  output logic          out_last,
  output logic          out_err
);

  localparam int LIMIT = ROWS * COLS;

  walk_state_e   state;
  logic [RW-1:0] cur_r, nxt_r_q;
  logic [CW-1:0] cur_c, nxt_c_q;
  logic          last_q, err_q;

  heading_t      hd;
  logic [RW-1:0] step_r;
  logic [CW-1:0] step_c;
  logic          leaves, spent;
  logic          accept, take, in_grid, fault;

  assign accept  = (state == WK_IDLE) && start;
  assign take    = (state == WK_SEND) && out_ready;
  assign in_grid = (int'(start_row) < ROWS) && (int'(start_col) < COLS);

  pw_heading_decode u_dec (
    .dir (rd_dir),
    .hd  (hd)
  );

  pw_neighbor #(
    .ROWS (ROWS),
    .COLS (COLS),
    .RW   (RW),
    .CW   (CW)
  ) u_nbr (
    .cur_r  (cur_r),
    .cur_c  (cur_c),
    .hd     (hd),
    .nxt_r  (step_r),
    .nxt_c  (step_c),
    .leaves (leaves)
  );

  pw_step_budget #(
    .LIMIT (LIMIT)
  ) u_budget (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (accept),
    .bump  (take),
    .spent (spent)
  );

  assign fault = !rd_src && (hd.none || hd.many || leaves || spent);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= WK_IDLE;
      cur_r   <= '0;
      cur_c   <= '0;
      nxt_r_q <= '0;
      nxt_c_q <= '0;
      last_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      unique case (state)
        WK_IDLE: begin
          if (start) begin
            cur_r <= start_row;
            cur_c <= start_col;
            if (in_grid) begin
              state <= WK_READ;
            end else begin
              last_q <= 1'b1;
              err_q  <= 1'b1;
              state  <= WK_SEND;
            end
          end
        end
        WK_READ: state <= WK_EVAL;
        WK_EVAL: begin
          last_q  <= rd_src || fault;
          err_q   <= fault;
          nxt_r_q <= step_r;
          nxt_c_q <= step_c;
          state   <= WK_SEND;
        end
        WK_SEND: begin
          if (out_ready) begin
            if (last_q) begin
              state <= WK_IDLE;
            end else begin
              cur_r <= nxt_r_q;
              cur_c <= nxt_c_q;
              state <= WK_READ;
            end
          end
        end
        default: state <= WK_IDLE;
      endcase
    end
  end

  assign busy      = (state != WK_IDLE);
  assign rd_en     = (state == WK_READ);
  assign rd_row    = cur_r;
  assign rd_col    = cur_c;
  assign out_valid = (state == WK_SEND);
  assign out_row   = cur_r;
  assign out_col   = cur_c;
  assign out_last  = last_q;
  assign out_err   = err_q;

endmodule

// File: rtl/path_retrace_walker_chk.sv
module path_retrace_walker_chk #(
  parameter  int ROWS = 24,
  parameter  int COLS = 25,
  localparam int RW   = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW   = (COLS > 1) ? $clog2(COLS) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          rd_en,
  input logic [RW-1:0] rd_row,
  input logic [CW-1:0] rd_col,
  input logic          out_valid,
  input logic          out_ready,
  input logic [RW-1:0] out_row,
  input logic [CW-1:0] out_col,
  input logic          out_last,
  input logic          out_err
);

  logic [RW-1:0] prev_r;
  logic [CW-1:0] prev_c;
  logic          have_prev;
  logic          adjacent;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_r    <= '0;
      prev_c    <= '0;
      have_prev <= 1'b0;
    end else if (out_valid && out_ready) begin
      prev_r    <= out_row;
      prev_c    <= out_col;
      have_prev <= !out_last;
    end
  end

  always_comb begin
    int dr, dc;
    dr = int'(rd_row) - int'(prev_r);
    dc = int'(rd_col) - int'(prev_c);
    if (dr < 0) dr = -dr;
    if (dc < 0) dc = -dc;
    adjacent = (dr + dc) == 1;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!out_valid && !rd_en)); // R1

  AST_STEP_ADJACENT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && have_prev) |-> adjacent); // R3

  AST_ERR_IS_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> out_last); // R5

  AST_BEAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_row) && $stable(out_col)
                                   && $stable(out_last) && $stable(out_err))); // R9

  AST_READ_IN_GRID: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> ((int'(rd_row) < ROWS) && (int'(rd_col) < COLS))); // R11

  AST_READ_NOT_WITH_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !rd_en); // R12

endmodule

bind path_retrace_walker path_retrace_walker_chk #(
  .ROWS (ROWS),
  .COLS (COLS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .rd_en     (rd_en),
  .rd_row    (rd_row),
  .rd_col    (rd_col),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_row   (out_row),
  .out_col   (out_col),
  .out_last  (out_last),
  .out_err   (out_err)
);

// File: tb/path_retrace_walker_tb.sv
module path_retrace_walker_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ROWS  = 6;
  localparam int COLS  = 7;
  localparam int RW    = 3;
  localparam int CW    = 3;
  localparam int LIMIT = ROWS * COLS;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [RW-1:0] start_row = '0;
  logic [CW-1:0] start_col = '0;
  logic          busy, rd_en, out_valid, out_last, out_err;
  logic          out_ready = 1'b0;
  logic [RW-1:0] rd_row, out_row;
  logic [CW-1:0] rd_col, out_col;
  logic [3:0]    rd_dir = '0;
  logic          rd_src = 1'b0;

  logic [3:0] dmap [ROWS][COLS];
  logic       smap [ROWS][COLS];

  int exp_r [64];
  int exp_c [64];
  bit exp_l [64];
  bit exp_e [64];
  int exp_n;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  path_retrace_walker #(.ROWS(ROWS), .COLS(COLS)) u_dut (
    .clk, .rst_n, .start, .start_row, .start_col, .busy,
    .rd_en, .rd_row, .rd_col, .rd_dir, .rd_src,
    .out_valid, .out_ready, .out_row, .out_col, .out_last, .out_err
  );

  // direction store model: one-cycle read
  always @(posedge clk) begin
    if (rd_en && int'(rd_row) < ROWS && int'(rd_col) < COLS) begin
      rd_dir <= dmap[rd_row][rd_col];
      rd_src <= smap[rd_row][rd_col];
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic clear_map();
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        dmap[r][c] = 4'b0000;
        smap[r][c] = 1'b0;
      end
  endtask

  // expected walk from the requirement rules
  task automatic build_exp(input int r0, input int c0);
    int r, c, nr, nc, ones;
    bit bad;
    logic [3:0] d;
    r = r0; c = c0; exp_n = 0;
    if (r >= ROWS || c >= COLS) begin
      exp_r[0] = r; exp_c[0] = c; exp_l[0] = 1; exp_e[0] = 1; exp_n = 1;
      return;
    end
    forever begin
      exp_r[exp_n] = r; exp_c[exp_n] = c; exp_l[exp_n] = 0; exp_e[exp_n] = 0;
      exp_n++;
      d = dmap[r][c];
      if (smap[r][c]) begin exp_l[exp_n-1] = 1; return; end
      ones = $countones(d);
      nr = r; nc = c; bad = 0;
      if (ones != 1) bad = 1;
      else if (d[0]) nr = r - 1;
      else if (d[1]) nr = r + 1;
      else if (d[2]) nc = c + 1;
      else nc = c - 1;
      if (nr < 0 || nr >= ROWS || nc < 0 || nc >= COLS) bad = 1;
      if (exp_n == LIMIT) bad = 1;
      if (bad) begin exp_l[exp_n-1] = 1; exp_e[exp_n-1] = 1; return; end
      r = nr; c = nc;
    end
  endtask

  task automatic run_walk(input int r0, input int c0, input int ready_pct,
                          input bit poke, input string tag);
    int beats = 0, reads = 0, cyc = 0;
    bit done = 0, hold = 0;
    int hr = 0, hc = 0;
    bit hl = 0, he = 0;
    build_exp(r0, c0);
    @(negedge clk);
    start = 1'b1; start_row = RW'(r0); start_col = CW'(c0);
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 3) begin
        start = 1'b1; start_row = RW'((r0 + 1) % ROWS); start_col = CW'((c0 + 2) % COLS);
      end else begin
        start = 1'b0;
      end
      if (hold) begin
        check(out_valid && int'(out_row) == hr && int'(out_col) == hc &&
              out_last == hl && out_err == he, "R9", "held beat row",
              int'(out_row), hr);
        hold = 0;
      end
      if (rd_en) begin
        if (beats < exp_n)
          check(int'(rd_row) == exp_r[beats] && int'(rd_col) == exp_c[beats],
                "R12", "read row*8+col", int'(rd_row) * 8 + int'(rd_col),
                exp_r[beats] * 8 + exp_c[beats]);
        reads++;
      end
      out_ready = (($urandom % 100) < ready_pct);
      if (out_valid) begin
        if (out_ready) begin
          if (beats < exp_n)
            check(int'(out_row) == exp_r[beats] && int'(out_col) == exp_c[beats] &&
                  out_last == exp_l[beats] && out_err == exp_e[beats], tag,
                  "beat {row,col,last,err}",
                  int'(out_row) * 1000 + int'(out_col) * 100 + int'(out_last) * 10 + int'(out_err),
                  exp_r[beats] * 1000 + exp_c[beats] * 100 + int'(exp_l[beats]) * 10 + int'(exp_e[beats]));
          beats++;
          if (out_last) done = 1;
        end else begin
          hold = 1; hr = int'(out_row); hc = int'(out_col); hl = out_last; he = out_err;
        end
      end
    end
    start = 1'b0;
    check(done, tag, "walk finished", int'(done), 1);
    check(beats == exp_n, tag, "beat count", beats, exp_n);
    check(reads == ((r0 < ROWS && c0 < COLS) ? exp_n : 0), "R12", "read count", reads,
          (r0 < ROWS && c0 < COLS) ? exp_n : 0);
    @(negedge clk);
    out_ready = 1'b0;
    check(!busy && !out_valid, "R10", "idle after walk", int'(busy), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_2024));
    clear_map();
    repeat (3) @(negedge clk);
    check(!busy && !out_valid && !rd_en, "R1", "reset idle", int'(busy | out_valid | rd_en), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !out_valid && !rd_en, "R1", "idle after reset release",
          int'(busy | out_valid | rd_en), 0);

    // R4: destination is itself an origin
    smap[2][3] = 1; dmap[2][3] = 4'b0010;
    run_walk(2, 3, 100, 0, "R4");

    // R2 R3: north/west route to origin with stray direction (R4)
    clear_map();
    smap[0][0] = 1; dmap[0][0] = 4'b0001;
    dmap[2][2] = 4'b0001; dmap[1][2] = 4'b1000;
    dmap[1][1] = 4'b0001; dmap[0][1] = 4'b1000;
    run_walk(2, 2, 100, 1, "R3");
    // south/east route, with back-pressure (R9)
    smap[5][6] = 1;
    dmap[3][4] = 4'b0010; dmap[4][4] = 4'b0100;
    dmap[4][5] = 4'b0010; dmap[5][5] = 4'b0100;
    run_walk(3, 4, 30, 0, "R2");

    // R5 unreached
    run_walk(3, 0, 100, 0, "R5");
    // R6 multi-bit
    dmap[1][4] = 4'b0101;
    run_walk(1, 4, 60, 0, "R6");
    // R7 leaving each edge
    dmap[0][5] = 4'b0001; run_walk(0, 5, 100, 0, "R7");
    dmap[5][3] = 4'b0010; run_walk(5, 3, 100, 0, "R7");
    dmap[2][6] = 4'b0100; run_walk(2, 6, 100, 0, "R7");
    dmap[4][0] = 4'b1000; run_walk(4, 0, 100, 0, "R7");

    // R8 loop capped at ROWS*COLS beats
    clear_map();
    dmap[0][0] = 4'b0100; dmap[0][1] = 4'b1000;
    run_walk(0, 0, 70, 0, "R8");

    // R11 destination outside grid
    run_walk(6, 2, 100, 0, "R11");
    run_walk(1, 7, 50, 0, "R11");

    // random maps
    for (int m = 0; m < 20; m++) begin
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++) begin
          int p;
          p = $urandom % 100;
          smap[r][c] = (p < 15);
          if (p < 25)      dmap[r][c] = 4'b0000;
          else if (p < 30) dmap[r][c] = 4'b0011 << ($urandom % 3);
          else             dmap[r][c] = 4'b0001 << ($urandom % 4);
        end
      for (int k = 0; k < 5; k++)
        run_walk($urandom % ROWS, $urandom % COLS, 40 + ($urandom % 61), (k == 2), "R3");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule